// File: doc/BRIEF.md
# Digit-Serial Ghost-Bit Field Multiplier

This block multiplies two elements of GF(2^N), where the field is reduced by the all-ones polynomial of degree N: every coefficient from x^N down to x^0 is one. Internally each operand is widened to N+1 coefficients, and the extra top coefficient (the ghost bit) is cleared on load. Arithmetic then runs modulo x^(N+1)+1. In that ring, multiplying by a power of x is a plain cyclic rotation, so no polynomial division is needed in the main loop.

The factor A is consumed least significant digit first, K bits per clock. Each digit selects one of 2^K precomputed multiples of B. The multiple is rotated into the weight of its digit and XORed into the accumulator C. After the last digit, a single conditional complement folds the ghost coefficient back, and the low N bits form the product. The table of B multiples is built when a job is accepted. It can be kept from the previous job when B has not changed. A caller pulses `start_i` while the block is idle, waits for `done_o`, and then reads `prod_o`.

Top module: `gbb_mult`

## Requirements
- R1: When `done_o` is high, `prod_o` equals A·B reduced modulo x^N + x^(N-1) + ... + x + 1. Bit i of each vector is the coefficient of x^i.
- R2: `done_o` is high for exactly one cycle, ND = ceil((N+1)/K) clock edges after the edge that accepts `start_i`. When K does not divide N+1, A is padded with zero digits.
- R3: `busy_o` rises on the edge that accepts `start_i`. It stays high until the edge that raises `done_o`, and at that edge it falls.
- R4: `start_i` is ignored while `busy_o` is high. The running job's product is unaffected by the operands presented with it.
- R5: When `reuse_b_i` is high as a job is accepted, `b_i` is ignored and the table built from the previously loaded B is used.
- R6: `prod_o` keeps its value from `done_o` until the next job completes.
- R7: A zero A or a zero B gives a zero product.
- R8: After reset, `busy_o`, `done_o` and `prod_o` are all zero.
- R9: If the ghost coefficient of the ring result is one, the full ring vector is complemented before truncation. For example, x^(N-1)·x gives the all-ones N-bit product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a job; sampled only when idle |
| reuse_b_i | input | 1 | Keep the previous table of B multiples |
| a_i | input | N | Factor A, consumed digit-serially |
| b_i | input | N | Factor B, expanded into the table |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |
| prod_o | output | N | Product, held until the next completion |

## Verification
The bench builds the block with N=12 and K=4. The ring then has 13 coefficients, which forces one zero padding digit and a four-cycle digit loop. This exercises the uneven digit split that the larger default field would also hit. With this small field, a schoolbook multiply followed by long division by the all-ones polynomial can serve as an independent reference for every product. The field is also small enough that products whose ring result carries a set ghost coefficient can be built on purpose. Table reuse is checked by changing `b_i` between jobs and confirming the old B is still applied.

// File: rtl/gbb_pkg.sv
package gbb_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/gbb_table.sv
module gbb_table #(
    parameter int W = 13,
    parameter int K = 4,
    localparam int TE = 1 << K
) (
    input  logic [W-1:0]          b_ring_i,
    output logic [TE-1:0][W-1:0]  tab_o
);
    logic [2*W-1:0] wide;

    always_comb begin
        for (int d = 0; d < TE; d++) begin
            tab_o[d] = '0;
            for (int j = 0; j < K; j++) begin
                if (((d >> j) & 1) == 1) begin
                    wide     = {b_ring_i, b_ring_i} << j;
                    tab_o[d] = tab_o[d] ^ wide[2*W-1:W];
                end
            end
        end
        wide = '0;
    end
endmodule

// File: rtl/gbb_rot.sv
module gbb_rot #(
    parameter int W  = 13,
    parameter int RW = 5
) (
    input  logic [W-1:0]  x_i,
    input  logic [RW-1:0] amt_i,
    output logic [W-1:0]  y_o
);
    logic [2*W-1:0] wide;

    always_comb begin
        wide = {x_i, x_i} << amt_i;
        y_o  = wide[2*W-1:W];
    end
endmodule

// File: rtl/gbb_reduce.sv
module gbb_reduce #(
    parameter int N = 12,
    localparam int W = N + 1
) (
    input  logic [W-1:0] ring_i,
    output logic [N-1:0] prod_o
);
    logic [W-1:0] folded;

    always_comb begin
        folded = ring_i[N] ? ~ring_i : ring_i;
        prod_o = folded[N-1:0];
    end
endmodule

// File: rtl/gbb_mult.sv
module gbb_mult
    import gbb_pkg::*;
#(
    parameter int N = 172,
    parameter int K = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         reuse_b_i,
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [N-1:0] prod_o
);
    localparam int W   = N + 1;
    localparam int ND  = ceil_div(W, K);
    localparam int AW  = ND * K;
    localparam int PAD = AW - N;
    localparam int TE  = 1 << K;
    localparam int CW  = $clog2(ND + 1);
    localparam int RW  = $clog2(W) + 1;

    typedef struct packed {
        phase_e                 phase;
        logic                   done;
        logic [AW-1:0]          a;
        logic [CW-1:0]          cnt;
        logic [W-1:0]           c;
        logic [N-1:0]           p;
        logic [TE-1:0][W-1:0]   tab;
    } state_t;

    state_t s_d, s_q;

    logic [TE-1:0][W-1:0] tab_new;
    logic [W-1:0]         entry;
    logic [W-1:0]         entry_rot;
    logic [W-1:0]         c_acc;
    logic [N-1:0]         prod_new;
    logic [RW-1:0]        rot_amt;
    logic [AW-1:0]        a_load;

    generate
        if (PAD > 0) begin : g_pad
            assign a_load = {{PAD{1'b0}}, a_i};
        end else begin : g_nopad
            assign a_load = a_i;
        end
    endgenerate

    gbb_table #(.W(W), .K(K)) i_table (
        .b_ring_i ({1'b0, b_i}),
        .tab_o    (tab_new)
    );

    assign entry   = s_q.tab[s_q.a[K-1:0]];
    assign rot_amt = RW'(s_q.cnt) * RW'(K);

    gbb_rot #(.W(W), .RW(RW)) i_rot (
        .x_i   (entry),
        .amt_i (rot_amt),
        .y_o   (entry_rot)
    );

    assign c_acc = s_q.c ^ entry_rot;

    gbb_reduce #(.N(N)) i_reduce (
        .ring_i (c_acc),
        .prod_o (prod_new)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    s_d.phase = PH_RUN;
                    s_d.a     = a_load;
                    s_d.cnt   = '0;
                    s_d.c     = '0;
                    if (!reuse_b_i) begin
                        s_d.tab = tab_new;
                    end
                end
            end
            PH_RUN: begin
                s_d.c   = c_acc;
                s_d.a   = s_q.a >> K;
                s_d.cnt = s_q.cnt + 1'b1;
                if (s_q.cnt == CW'(ND - 1)) begin
                    s_d.phase = PH_IDLE;
                    s_d.done  = 1'b1;
                    s_d.p     = prod_new;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o = (s_q.phase == PH_RUN);
    assign done_o = s_q.done;
    assign prod_o = s_q.p;
endmodule

// File: rtl/gbb_mult_chk.sv
module gbb_mult_chk #(
    parameter int N = 172,
    parameter int K = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [N-1:0] prod_o
);
    localparam int ND = (N + K) / K;

    logic [31:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (start_i && !busy_o) begin
            run_cnt <= '0;
        end else if (busy_o) begin
            run_cnt <= run_cnt + 1;
        end
    end

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (run_cnt == 32'(ND)));

    assert_busy_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    assert_busy_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(prod_o));

    assert_run_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> (done_o || $stable(prod_o)));
endmodule

bind gbb_mult gbb_mult_chk #(.N(N), .K(K)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .prod_o  (prod_o)
);

// File: tb/test_gbb_mult.sv
`timescale 1ns/1ps
module test_gbb_mult;
    localparam int N  = 12;
    localparam int K  = 4;
    localparam int ND = (N + K) / K;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         reuse_b_i = 1'b0;
    logic [N-1:0] a_i = '0;
    logic [N-1:0] b_i = '0;
    logic         busy_o;
    logic         done_o;
    logic [N-1:0] prod_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    gbb_mult #(.N(N), .K(K)) i_gbb_mult (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .reuse_b_i(reuse_b_i),
        .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .done_o(done_o), .prod_o(prod_o)
    );

    function automatic logic [N-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
        logic [2*N-1:0] prod = '0;
        logic [2*N-1:0] mod_ones = {{(N-1){1'b0}}, {(N+1){1'b1}}};
        for (int i = 0; i < N; i++)
            if (a[i]) prod = prod ^ ({{N{1'b0}}, b} << i);
        for (int deg = 2*N-1; deg >= N; deg--)
            if (prod[deg]) prod = prod ^ (mod_ones << (deg - N));
        return prod[N-1:0];
    endfunction

    task automatic check(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b,
                          input logic reuse, input logic [N-1:0] expv, input string tag);
        int n;
        @(negedge clk);
        a_i = a; b_i = b; reuse_b_i = reuse; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; reuse_b_i = 1'b0;
        check(busy_o == 1'b1, "R3 busy after start", busy_o, 1);
        n = 0;
        while (!done_o && n < 40) begin
            @(negedge clk);
            n++;
        end
        check(n == ND, "R2 latency", n, ND);
        check(busy_o == 1'b0, "R3 busy low at done", busy_o, 0);
        check(prod_o == expv, tag, prod_o, expv);
        @(negedge clk);
        check(done_o == 1'b0, "R2 single pulse", done_o, 0);
        check(prod_o == expv, "R6 held after done", prod_o, expv);
    endtask

    task automatic t_reset();
        check(busy_o == 1'b0, "R8 busy", busy_o, 0);
        check(done_o == 1'b0, "R8 done", done_o, 0);
        check(prod_o == '0, "R8 product", prod_o, 0);
    endtask

    task automatic t_patterns();
        for (int i = 0; i < 24; i++) begin
            logic [N-1:0] a = N'(i * 1237 + 91);
            logic [N-1:0] b = N'(i * 2749 + 3001);
            run_op(a, b, 1'b0, ref_mul(a, b), "R1 product");
        end
        run_op({N{1'b1}}, {N{1'b1}}, 1'b0, ref_mul({N{1'b1}}, {N{1'b1}}), "R1 all ones");
        run_op(N'(1), N'(12'h5a3), 1'b0, N'(12'h5a3), "R1 identity");
    endtask

    task automatic t_ghost();
        logic [N-1:0] top = '0;
        top[N-1] = 1'b1;
        run_op(top, N'(2), 1'b0, {N{1'b1}}, "R9 ghost fold");
        run_op(top, top, 1'b0, ref_mul(top, top), "R9 high powers");
    endtask

    task automatic t_zero();
        run_op('0, N'(12'hbee), 1'b0, '0, "R7 zero A");
        run_op(N'(12'h777), '0, 1'b0, '0, "R7 zero B");
    endtask

    task automatic t_reuse();
        logic [N-1:0] b0 = N'(12'h3c9);
        run_op(N'(12'h111), b0, 1'b0, ref_mul(N'(12'h111), b0), "R1 load for reuse");
        run_op(N'(12'h8e2), N'(12'hfff), 1'b1, ref_mul(N'(12'h8e2), b0), "R5 reuse keeps B");
        run_op(N'(12'h8e2), N'(12'h0f0), 1'b0, ref_mul(N'(12'h8e2), N'(12'h0f0)), "R5 reload B");
    endtask

    task automatic t_busy_ignore();
        logic [N-1:0] a1 = N'(12'h9a7);
        logic [N-1:0] b1 = N'(12'h4d1);
        logic [N-1:0] e1 = ref_mul(a1, b1);
        int n;
        @(negedge clk);
        a_i = a1; b_i = b1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        a_i = N'(12'h001); b_i = N'(12'h001); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 2;
        while (!done_o && n < 40) begin
            @(negedge clk);
            n++;
        end
        check(n == ND, "R4 latency unchanged", n, ND);
        check(prod_o == e1, "R4 start ignored while busy", prod_o, e1);
        @(negedge clk);
        check(busy_o == 1'b0, "R4 no second job", busy_o, 0);
    endtask

    task automatic t_hold();
        logic [N-1:0] e = ref_mul(N'(12'h6b5), N'(12'h2c8));
        run_op(N'(12'h6b5), N'(12'h2c8), 1'b0, e, "R1 before hold");
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            a_i = N'(i * 311); b_i = N'(i * 97); reuse_b_i = i[0];
        end
        check(prod_o == e, "R6 idle hold", prod_o, e);
        check(done_o == 1'b0, "R6 no spurious done", done_o, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R2 watchdog expired actual=hung expected=finish");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_patterns();
        t_ghost();
        t_zero();
        t_reuse();
        t_busy_ignore();
        t_hold();
        repeat (3) @(negedge clk);
        summary();
    end
endmodule